// File: doc/BRIEF.md
# Comma-Framed Byte-to-Word Deserializer

This block sits behind a character decoder on a receive link. It takes one 8-bit character per cycle, together with a flag that marks control characters and a flag that reports link alignment. It packs each four characters into a 32-bit word. A comma, which is a control character with a fixed code, always opens a word. The block also produces a recovered clock at one quarter of the character rate.

A comma resets two things: the byte-lane counter that steers the demultiplexer, and the divide-by-4 counter behind the slow clock. As a result, word framing and the slow clock phase follow the comma after every relock. They do not depend on where the divider happened to be when the link came up. The rising edge of the slow clock falls two character cycles after the output register loads, which is the middle of the stable window of the registered word.

Lanes that come after the comma take any character. A comma that arrives in a lane other than lane 0 sets a sticky error flag. Framing then restarts at that comma.

Top module: `comma_word_deser`

## Requirements
- R1: While reset is held, `lane_sel` is 0, `word_stb` is 0, `slow_clk` is 0, `frame_err` is 0 and `word_out` is 0.
- R2: While `aligned` is low, characters are ignored and no word is produced. In the cycle after a low `aligned` is sampled, `lane_sel` is 0, `slow_clk` is 0 and framing is cleared.
- R3: A comma is a cycle with `char_is_k` high and `char_in` equal to the `COMMA` parameter (default 8'hBC). Before the first comma after alignment, `word_stb` never rises.
- R4: An accepted comma is stored in lane 0 (`word_out[7:0]`), and `lane_sel` reads 1 afterwards. The next three characters fill lanes 1, 2 and 3, which are bits 15:8, 23:16 and 31:24.
- R5: While framed, `word_stb` is high for exactly one cycle in every four. It is high in the cycle in which `word_out` shows the newly completed word, and `lane_sel` is then 0.
- R6: After a comma, `slow_clk` is high exactly while `lane_sel` is 2 or 3, which gives a 50% duty cycle. Its rising edge comes two cycles after `word_stb` rises.
- R7: A comma that arrives when `lane_sel` is 0 in the framed state opens the next word without any error.
- R8: A comma that arrives while framed with `lane_sel` non-zero does three things. It sets `frame_err`, which stays high until reset. It discards the partial word. It restarts framing with that comma in lane 0.
- R9: A control character with any code other than `COMMA`, or the `COMMA` code without `char_is_k`, is treated as ordinary data in its lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aligned | input | 1 | Link symbol alignment achieved |
| char_in | input | 8 | Decoded character |
| char_is_k | input | 1 | Character is a control character |
| lane_sel | output | 2 | Byte lane the next character will fill |
| word_stb | output | 1 | One-cycle pulse marking a new `word_out` |
| word_out | output | 32 | Registered assembled word |
| slow_clk | output | 1 | Divide-by-4 word-rate clock |
| frame_err | output | 1 | Sticky misplaced-comma flag |

## Verification
The hardest state to reach is a comma that lands in lane 1, 2 or 3 after framing is already established. The error flag must rise while the captured word still starts at the new comma. The bench reaches this state by building a clean frame and then inserting a comma after one data byte. It then completes the re-framed word and checks both the error flag and the word contents. The divider-resynchronisation claim rests on comma placement, so the bench also sweeps the number of unframed characters before the first comma over every phase of the free-running divider, and checks the slow-clock pattern after each.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  localparam int CHAR_W = 8;

  function automatic logic is_comma(input logic [CHAR_W-1:0] ch,
                                    input logic k,
                                    input logic [CHAR_W-1:0] code);
    return k && (ch == code);
  endfunction

  function automatic logic [1:0] lane_step(input logic [1:0] cur);
    return cur + 2'd1;
  endfunction
endpackage

// File: rtl/cwd_lane_ctrl.sv
module cwd_lane_ctrl #(
  parameter int LANES = 4,
  localparam int LW = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          aligned,
  input  logic          comma,
  output logic [LW-1:0] lane_q,
  output logic          framed_q,
  output logic          err_q,
  output logic          take,
  output logic [LW-1:0] wr_idx,
  output logic          misplaced
);
  assign misplaced = aligned && comma && framed_q && (lane_q != '0);
  assign take      = aligned && (framed_q || comma);
  assign wr_idx    = comma ? '0 : lane_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q   <= '0;
      framed_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (misplaced) err_q <= 1'b1;
      if (!aligned) begin
        lane_q   <= '0;
        framed_q <= 1'b0;
      end else if (comma) begin
        lane_q   <= LW'(1);
        framed_q <= 1'b1;
      end else if (framed_q) begin
        lane_q   <= lane_q + LW'(1);
      end
    end
  end
endmodule

// File: rtl/cwd_clkdiv.sv
module cwd_clkdiv #(
  parameter int LANES = 4,
  localparam int LW = $clog2(LANES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic aligned,
  input  logic resync,
  output logic slow_clk
);
  logic [LW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !aligned) div_q <= '0;
    else if (resync)        div_q <= LW'(1);
    else                    div_q <= div_q + LW'(1);
  end

  assign slow_clk = div_q[LW-1];
endmodule

// File: rtl/cwd_word_pack.sv
module cwd_word_pack #(
  parameter int LANES = 4,
  parameter int CW = 8,
  localparam int LW = $clog2(LANES),
  localparam int WW = LANES * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [LW-1:0] wr_idx,
  input  logic [CW-1:0] ch,
  output logic [WW-1:0] word_q,
  output logic          stb_q
);
  logic [CW-1:0] hold_q [LANES-1];
  logic [WW-1:0] full_w;
  logic          load_w;

  assign load_w = take && (wr_idx == LW'(LANES-1));

  for (genvar i = 0; i < LANES-1; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) hold_q[i] <= '0;
      else if (take && wr_idx == LW'(i)) hold_q[i] <= ch;
    end
    assign full_w[i*CW +: CW] = hold_q[i];
  end
  assign full_w[WW-1 -: CW] = ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= load_w;
      if (load_w) word_q <= full_w;
    end
  end
endmodule

// File: rtl/comma_word_deser.sv
module comma_word_deser #(
  parameter logic [7:0] COMMA = 8'hBC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        aligned,
  input  logic [7:0]  char_in,
  input  logic        char_is_k,
  output logic [1:0]  lane_sel,
  output logic        word_stb,
  output logic [31:0] word_out,
  output logic        slow_clk,
  output logic        frame_err
);
  import cwd_pkg::*;
  localparam int LANES = 4;
  localparam int LW = $clog2(LANES);

  logic          comma_hit;
  logic          framed_w;
  logic          take_w;
  logic          misplaced_w;
  logic [LW-1:0] wr_idx_w;

  assign comma_hit = is_comma(char_in, char_is_k, COMMA);

  cwd_lane_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .aligned(aligned), .comma(comma_hit),
    .lane_q(lane_sel), .framed_q(framed_w), .err_q(frame_err),
    .take(take_w), .wr_idx(wr_idx_w), .misplaced(misplaced_w)
  );

  cwd_clkdiv #(.LANES(LANES)) u_div (
    .clk(clk), .rst_n(rst_n), .aligned(aligned),
    .resync(comma_hit), .slow_clk(slow_clk)
  );

  cwd_word_pack #(.LANES(LANES), .CW(8)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(take_w), .wr_idx(wr_idx_w),
    .ch(char_in), .word_q(word_out), .stb_q(word_stb)
  );
endmodule

// File: rtl/cwd_checker.sv
module cwd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       aligned,
  input logic [1:0] lane_sel,
  input logic       word_stb,
  input logic       slow_clk,
  input logic       frame_err,
  input logic       framed,
  input logic       comma_hit,
  input logic       misplaced
);
  AST_UNALIGNED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |=> (lane_sel == 2'd0) && !framed && !slow_clk); // R2
  AST_COMMA_LANE1: assert property (@(posedge clk) disable iff (!rst_n)
    aligned && comma_hit |=> lane_sel == 2'd1); // R4
  AST_LANE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    aligned && framed && !comma_hit |=> lane_sel == $past(lane_sel) + 2'd1); // R5
  AST_STB_AT_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> lane_sel == 2'd0); // R5
  AST_SLOW_TRACKS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    framed |-> slow_clk == lane_sel[1]); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err); // R8
  AST_ERR_ON_MISPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    misplaced |=> frame_err); // R8
endmodule

bind comma_word_deser cwd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .aligned(aligned), .lane_sel(lane_sel),
  .word_stb(word_stb), .slow_clk(slow_clk), .frame_err(frame_err),
  .framed(framed_w), .comma_hit(comma_hit), .misplaced(misplaced_w)
);

// File: tb/tb_comma_word_deser.sv
module tb_comma_word_deser;
  localparam logic [7:0] K_COMMA = 8'hBC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aligned = 1'b0;
  logic [7:0]  char_in = 8'h00;
  logic        char_is_k = 1'b0;
  logic [1:0]  lane_sel;
  logic        word_stb;
  logic [31:0] word_out;
  logic        slow_clk;
  logic        frame_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  comma_word_deser dut (
    .clk(clk), .rst_n(rst_n), .aligned(aligned), .char_in(char_in),
    .char_is_k(char_is_k), .lane_sel(lane_sel), .word_stb(word_stb),
    .word_out(word_out), .slow_clk(slow_clk), .frame_err(frame_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] b, input logic k, input logic a);
    char_in = b; char_is_k = k; aligned = a;
    @(posedge clk); #1;
  endtask

  // expected slow clock for a given lane once framed: high in the upper half
  function automatic logic slow_of(input int lane);
    return (lane % 4) >= 2;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] b1, b2, b3;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1 lane", {30'd0, lane_sel}, 32'd0);
    chk("R1 stb", {31'd0, word_stb}, 32'd0);
    chk("R1 slow", {31'd0, slow_clk}, 32'd0);
    chk("R1 err", {31'd0, frame_err}, 32'd0);
    chk("R1 word", word_out, 32'd0);
    rst_n = 1'b1;

    // R2 commas and data ignored while not aligned
    for (int i = 0; i < 6; i++) begin
      step((i % 2) ? K_COMMA : 8'h55, 1'b1, 1'b0);
      chk("R2 lane", {30'd0, lane_sel}, 32'd0);
      chk("R2 stb", {31'd0, word_stb}, 32'd0);
      chk("R2 slow", {31'd0, slow_clk}, 32'd0);
    end

    // sweep pre-comma junk length over every divider phase
    for (int pre = 0; pre < 8; pre++) begin
      for (int j = 0; j < pre; j++) begin
        step(8'h10 + 8'(j), 1'b0, 1'b1);
        chk("R3 no stb before comma", {31'd0, word_stb}, 32'd0);
      end
      for (int w = 0; w < 3; w++) begin
        step(K_COMMA, 1'b1, 1'b1);
        chk("R4 lane after comma", {30'd0, lane_sel}, 32'd1);
        chk("R6 slow after comma", {31'd0, slow_clk}, 32'd0);
        if (w > 0) chk("R5 stb once", {31'd0, word_stb}, 32'd0);
        b1 = 8'(pre * 32 + w * 4 + 1);
        b2 = 8'(pre * 32 + w * 4 + 2);
        b3 = 8'(pre * 32 + w * 4 + 3);
        // R9: in word 1 a non-comma K code and a comma code without K are data
        if (w == 1) begin b1 = 8'h1C; b2 = K_COMMA; end
        step(b1, (w == 1), 1'b1);
        chk("R4 lane1", {30'd0, lane_sel}, 32'd2);
        chk("R6 slow lane2", {31'd0, slow_clk}, {31'd0, slow_of(2)});
        chk("R5 no stb mid", {31'd0, word_stb}, 32'd0);
        step(b2, 1'b0, 1'b1);
        chk("R4 lane2", {30'd0, lane_sel}, 32'd3);
        chk("R6 slow lane3", {31'd0, slow_clk}, {31'd0, slow_of(3)});
        step(b3, 1'b0, 1'b1);
        chk("R5 stb", {31'd0, word_stb}, 32'd1);
        chk("R5 lane0 at stb", {30'd0, lane_sel}, 32'd0);
        chk("R4 word", word_out, {b3, b2, b1, K_COMMA});
        chk("R6 slow low at stb", {31'd0, slow_clk}, 32'd0);
      end
      // R5/R6 free word after last comma: lane 0 takes data, slow rises 2 after stb
      step(8'hA0, 1'b0, 1'b1);
      chk("R5 stb single", {31'd0, word_stb}, 32'd0);
      chk("R6 slow lane1", {31'd0, slow_clk}, 32'd0);
      step(8'hA1, 1'b0, 1'b1);
      chk("R6 slow rise", {31'd0, slow_clk}, 32'd1);
      step(8'hA2, 1'b0, 1'b1);
      step(8'hA3, 1'b0, 1'b1);
      chk("R5 data-led word", word_out, 32'hA3A2A1A0);
      chk("R5 stb data word", {31'd0, word_stb}, 32'd1);
      chk("R7 no err", {31'd0, frame_err}, 32'd0);
      // R2 drop alignment clears framing
      step(8'h77, 1'b0, 1'b0);
      chk("R2 lane cleared", {30'd0, lane_sel}, 32'd0);
      chk("R2 slow cleared", {31'd0, slow_clk}, 32'd0);
      for (int j = 0; j < 4; j++) begin
        step(8'h66, 1'b0, 1'b1);
        chk("R2 no stb after relock", {31'd0, word_stb}, 32'd0);
      end
    end

    // R8 misplaced comma
    step(K_COMMA, 1'b1, 1'b1);
    step(8'hE1, 1'b0, 1'b1);
    chk("R8 err before", {31'd0, frame_err}, 32'd0);
    step(K_COMMA, 1'b1, 1'b1);
    chk("R8 err set", {31'd0, frame_err}, 32'd1);
    chk("R8 reframed lane", {30'd0, lane_sel}, 32'd1);
    chk("R8 slow reframed", {31'd0, slow_clk}, 32'd0);
    step(8'hF1, 1'b0, 1'b1);
    step(8'hF2, 1'b0, 1'b1);
    chk("R8 no stb partial", {31'd0, word_stb}, 32'd0);
    step(8'hF3, 1'b0, 1'b1);
    chk("R8 stb", {31'd0, word_stb}, 32'd1);
    chk("R8 word", word_out, {8'hF3, 8'hF2, 8'hF1, K_COMMA});
    step(8'h00, 1'b0, 1'b0);
    step(K_COMMA, 1'b1, 1'b1);
    chk("R8 sticky", {31'd0, frame_err}, 32'd1);
    rst_n = 1'b0;
    step(8'h00, 1'b0, 1'b0);
    chk("R1 err cleared by reset", {31'd0, frame_err}, 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule